// File: doc/BRIEF.md
# Catch-up Position Encoder

This block turns the outputs of a chasing-edge delay measurement into a binary position. It watches a parameterised word of comparator outputs, 30 taps by default, drawn from two interleaved comparator chains. Each tap goes high once the late edge has overtaken the early edge at that stage. Every tap passes through a sticky capture bank that registers only 0-to-1 changes. Once the comparators start pulsing periodically after catch-up, their falling edges therefore cannot create false boundaries.

A boundary counts as valid only where a captured tap is set and the two taps just below it are both clear. This three-tap rule makes the block tolerant of single bubbles and blind to boundaries squeezed against the least significant end. The lowest valid boundary is latched as a 5-bit index, and a valid flag rises with it. From then on the block ignores its inputs until a new conversion is started with `clear`. An outside correction circuit can empty the capture bank with `corrClr` while no result is held.

Top module: `catchup_encoder`

## Requirements
- R1: After reset, `catchValid` is 0 and `catchPos` is 0.
- R2: A 0-to-1 change on `arbIn[i]` sets capture bit i. The bit stays set after the input returns to 0, so a single-cycle input pulse still yields a result.
- R3: An input that is already high when a conversion starts, and an input that falls, never set a capture bit.
- R4: Capture bit i (2 ≤ i ≤ NUM_TAPS-1) forms a boundary when bit i is set and bits i-1 and i-2 are both clear. `catchPos` reports i in plain binary, with index 0 being `arbIn[0]`. Boundaries at index 0 or 1 are never reported.
- R5: A set bit with a set bit one or two places below it is not a boundary. A bubble or a pattern near the least significant end therefore produces no result.
- R6: When several boundaries are present at once, the lowest index is reported.
- R7: While `catchValid` is 1 and `clear` is low, `catchPos` and `catchValid` hold, whatever `arbIn` and `corrClr` do.
- R8: `corrClr` asserted with no result held empties the capture bank and blocks latching on that edge. Later boundaries are judged only on captures made after it.
- R9: `clear` drives `catchValid` and `catchPos` to 0 on the next edge, empties the capture bank and starts a new conversion.
- R10: An input rise sampled on clock edge k shows up as `catchValid`=1 with its `catchPos` on edge k+1. Both change on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Start a new conversion: drop the result, empty the capture bank |
| corrClr | input | 1 | Correction request: empty the capture bank while no result is held |
| arbIn | input | NUM_TAPS | Comparator outputs, index 0 at the least significant end |
| catchValid | output | 1 | A boundary has been latched |
| catchPos | output | $clog2(NUM_TAPS) | Index of the latched boundary, 0 when none |

## Verification
The checker watches four things on every cycle. The reported index always stays within the legal range while valid. The held result is stable until `clear`. `clear` zeroes the outputs on the following edge. Neither `clear` nor `corrClr` ever lets a result appear on the edge they are sampled.

Some behaviour can only be shown through the bench's directed conversions, because it depends on the contents of the capture bank:
- the rising-only capture of pulses, held inputs and falling inputs;
- the three-tap pattern rule with its bubble and low-end rejection;
- lowest-index priority;
- the correction flush followed by a fresh boundary;
- the exact latency of one extra edge.

// File: rtl/catchup_pkg.sv
package catchup_pkg;

  // Strobes from the control FSM to the capture datapath
  typedef struct packed {
    logic bankClr;   // empty the capture bank
    logic bankEn;    // allow new rising captures
    logic posLatch;  // load the encoded boundary index
    logic posClr;    // zero the index register
  } catchStrobes_t;

  typedef enum logic {
    ST_WATCH = 1'b0,
    ST_HELD  = 1'b1
  } catchState_e;

endpackage

// File: rtl/catchup_dp.sv
module catchup_dp
  import catchup_pkg::*;
#(
  parameter int NUM_TAPS = 30,
  parameter int POS_W    = $clog2(NUM_TAPS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_TAPS-1:0] arbIn,
  input  catchStrobes_t       strb,
  output logic                found,
  output logic [POS_W-1:0]    posOut
);

  logic [NUM_TAPS-1:0] prevArb;
  logic [NUM_TAPS-1:0] riseHit;
  logic [NUM_TAPS-1:0] bank;
  logic [NUM_TAPS-1:0] matchVec;
  logic [POS_W-1:0]    matchIdx;

  // Previous sample of every tap, always tracking, for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevArb <= '0;
    else       prevArb <= arbIn;
  end

  assign riseHit = arbIn & ~prevArb;

  // Sticky capture bank: only rising changes set a bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             bank <= '0;
    else if (strb.bankClr) bank <= '0;
    else if (strb.bankEn)  bank <= bank | riseHit;
  end

  // Three-tap boundary pattern: set bit above two clear bits
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_pat
    if (g < 2) begin : g_low
      assign matchVec[g] = 1'b0;
    end else begin : g_mid
      assign matchVec[g] = bank[g] & ~bank[g-1] & ~bank[g-2];
    end
  end

  assign found = |matchVec;

  // Lowest-index priority encoder
  always_comb begin
    matchIdx = '0;
    for (int i = NUM_TAPS - 1; i >= 0; i--) begin
      if (matchVec[i]) matchIdx = POS_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              posOut <= '0;
    else if (strb.posClr)   posOut <= '0;
    else if (strb.posLatch) posOut <= matchIdx;
  end

endmodule

// File: rtl/catchup_ctrl.sv
module catchup_ctrl
  import catchup_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          clear,
  input  logic          corrClr,
  input  logic          found,
  output catchStrobes_t strb,
  output logic          held
);

  catchState_e state, stateNext;
  logic        watching;

  assign watching = (state == ST_WATCH);

  always_comb begin
    strb.bankClr  = clear | (corrClr & watching);
    strb.bankEn   = watching & ~clear & ~corrClr;
    strb.posLatch = watching & found & ~clear & ~corrClr;
    strb.posClr   = clear;
  end

  always_comb begin
    stateNext = state;
    if (clear)              stateNext = ST_WATCH;
    else if (strb.posLatch) stateNext = ST_HELD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_WATCH;
    else       state <= stateNext;
  end

  assign held = (state == ST_HELD);

endmodule

// File: rtl/catchup_encoder.sv
module catchup_encoder
  import catchup_pkg::*;
#(
  parameter int NUM_TAPS = 30,
  localparam int POS_W   = $clog2(NUM_TAPS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clear,
  input  logic                corrClr,
  input  logic [NUM_TAPS-1:0] arbIn,
  output logic                catchValid,
  output logic [POS_W-1:0]    catchPos
);

  catchStrobes_t strb;
  logic          found;

  catchup_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .clear   (clear),
    .corrClr (corrClr),
    .found   (found),
    .strb    (strb),
    .held    (catchValid)
  );

  catchup_dp #(
    .NUM_TAPS (NUM_TAPS),
    .POS_W    (POS_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .arbIn  (arbIn),
    .strb   (strb),
    .found  (found),
    .posOut (catchPos)
  );

endmodule

// File: rtl/catchup_encoder_chk.sv
module catchup_encoder_chk #(
  parameter int NUM_TAPS = 30,
  localparam int POS_W   = $clog2(NUM_TAPS)
) (
  input logic             clk,
  input logic             rstN,
  input logic             clear,
  input logic             corrClr,
  input logic             catchValid,
  input logic [POS_W-1:0] catchPos
);

  // R4
  pos_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    catchValid |-> (catchPos >= POS_W'(2) && catchPos <= POS_W'(NUM_TAPS - 1)));

  // R7
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (catchValid && !clear) |=> (catchValid && $stable(catchPos)));

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (!catchValid && catchPos == '0));

  // R8
  corr_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (corrClr && !catchValid) |=> !catchValid);

  // R10
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(catchValid) |-> ($past(!clear) && $past(!corrClr)));

endmodule

bind catchup_encoder catchup_encoder_chk #(.NUM_TAPS(NUM_TAPS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .clear      (clear),
  .corrClr    (corrClr),
  .catchValid (catchValid),
  .catchPos   (catchPos)
);

// File: tb/catchup_encoder_bench.sv
`timescale 1ns/1ps
module catchup_encoder_bench;

  localparam int NUM_TAPS = 30;
  localparam int POS_W    = $clog2(NUM_TAPS);

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                clear = 1'b0;
  logic                corrClr = 1'b0;
  logic [NUM_TAPS-1:0] arbIn = '0;
  logic                catchValid;
  logic [POS_W-1:0]    catchPos;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  catchup_encoder #(.NUM_TAPS(NUM_TAPS)) u_catchup_encoder (
    .clk        (clk),
    .rstN       (rstN),
    .clear      (clear),
    .corrClr    (corrClr),
    .arbIn      (arbIn),
    .catchValid (catchValid),
    .catchPos   (catchPos)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic checkOut(input string req, input bit expV, input int expP);
    checks++;
    if (catchValid !== expV || int'(catchPos) != expP) begin
      errors++;
      $display("FAIL %s: actual valid=%0b pos=%0d expected valid=%0b pos=%0d",
               req, catchValid, catchPos, expV, expP);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic logic [NUM_TAPS-1:0] bitAt(input int idx);
    logic [NUM_TAPS-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  task automatic doClear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
  endtask

  task automatic t_reset();
    waitNeg(1);
    checkOut("R1 reset", 1'b0, 0);
  endtask

  task automatic t_pulse();
    doClear();
    arbIn = bitAt(7);
    @(negedge clk); arbIn = '0;
    checkOut("R10 not yet", 1'b0, 0);
    @(negedge clk);
    checkOut("R2 pulse captured", 1'b1, 7);
    checkOut("R10 latency", 1'b1, 7);
    doClear();
    checkOut("R9 clear", 1'b0, 0);
  endtask

  task automatic t_held();
    @(negedge clk); arbIn = bitAt(12);
    waitNeg(2);
    checkOut("R4 tap12", 1'b1, 12);
    doClear();
    waitNeg(3);
    checkOut("R3 held input", 1'b0, 0);
    arbIn = '0;
    waitNeg(3);
    checkOut("R3 falling input", 1'b0, 0);
    arbIn = bitAt(4);
    waitNeg(2);
    checkOut("R3 fresh rise", 1'b1, 4);
  endtask

  task automatic t_lowEnd();
    @(negedge clk); arbIn = '0;
    doClear();
    arbIn = bitAt(1) | bitAt(3);
    waitNeg(3);
    checkOut("R5 low end", 1'b0, 0);
    arbIn = arbIn | bitAt(5);
    waitNeg(3);
    checkOut("R5 bubble", 1'b0, 0);
    arbIn = arbIn | bitAt(9);
    waitNeg(2);
    checkOut("R4 after bubble", 1'b1, 9);
  endtask

  task automatic t_multi();
    @(negedge clk); arbIn = '0;
    doClear();
    arbIn = bitAt(6) | bitAt(15) | bitAt(22);
    waitNeg(2);
    checkOut("R6 lowest wins", 1'b1, 6);
    // freeze: new activity and correction are ignored
    arbIn = '1;
    @(negedge clk); corrClr = 1'b1;
    @(negedge clk); corrClr = 1'b0; arbIn = '0;
    waitNeg(2);
    checkOut("R7 frozen", 1'b1, 6);
  endtask

  task automatic t_edges();
    @(negedge clk); arbIn = '0;
    doClear();
    arbIn = bitAt(29);
    waitNeg(2);
    checkOut("R4 top tap", 1'b1, 29);
    @(negedge clk); arbIn = '0;
    doClear();
    arbIn = bitAt(2);
    waitNeg(2);
    checkOut("R4 lowest legal tap", 1'b1, 2);
  endtask

  task automatic t_corr();
    @(negedge clk); arbIn = '0;
    doClear();
    arbIn = bitAt(20);
    @(negedge clk); corrClr = 1'b1;
    @(negedge clk); corrClr = 1'b0;
    checkOut("R8 blocked", 1'b0, 0);
    waitNeg(2);
    checkOut("R8 bank flushed", 1'b0, 0);
    arbIn = arbIn | bitAt(8);
    waitNeg(2);
    checkOut("R8 fresh boundary", 1'b1, 8);
  endtask

  initial begin
    waitNeg(3);
    rstN = 1'b1;
    t_reset();
    t_pulse();
    t_held();
    t_lowEnd();
    t_multi();
    t_edges();
    t_corr();
    @(negedge clk); arbIn = '0;
    doClear();
    checkOut("R9 final clear", 1'b0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule